// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts the direction of conditional branches by combining two independent direction predictors and learning, per branch address, which of the two to believe. The first component hashes a shared global outcome history with the branch address (bitwise XOR) to pick one 2-bit saturating counter from a single shared table. The second component picks a 2-bit saturating counter using only the low branch address bits. A third table of 2-bit chooser counters, also indexed by low address bits, picks the final answer.

Prediction is a purely combinational lookup on the predict port. When a branch resolves, the update port delivers the address, the real outcome and the two component guesses as they were made. On that clock edge both component counters are trained toward the real outcome, the chooser counter is moved toward whichever component alone was right, and the global history shifts in the outcome. Target address lookup and recovery of speculatively shifted history are handled elsewhere.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every component counter holds 01 and every chooser holds 10, so `pr_glob`, `pr_local` and `pr_final` are all 0 for every address while the history is all zeros.
- R2: The global component reads the counter at index `pr_pc[HIST_W-1:0] XOR history`, and `pr_glob` is that counter's upper bit (1 = taken); an update writes the counter at `up_pc[HIST_W-1:0] XOR history`, using the history held before the update edge.
- R3: The local component reads and writes the counter at index `pc[LOC_W-1:0]`; `pr_local` is its upper bit.
- R4: Component counters saturate: an update with `up_taken`=1 moves a counter up by one but not past 11, and `up_taken`=0 moves it down by one but not below 00.
- R5: Every valid update trains both component counters, whatever the chooser currently selects.
- R6: `pr_final` equals `pr_glob` when the chooser at `pr_pc[SEL_W-1:0]` is 10 or 11, and `pr_local` when it is 00 or 01.
- R7: On a valid update the chooser at `up_pc[SEL_W-1:0]` steps up (saturating at 11) when only the global guess matched `up_taken`, and steps down (saturating at 00) when only the local guess matched.
- R8: The chooser is left as it was when both guesses were right or both were wrong.
- R9: On each valid update the history shifts left by one and takes `up_taken` into bit 0; the oldest bit is dropped.
- R10: A lookup in the same cycle as an update to the same entries returns the values from before that update; the new values appear from the following cycle.
- R11: With `up_valid` low no counter, chooser or history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pr_pc | input | ADDR_W | Low branch address bits for a lookup |
| pr_final | output | 1 | Chosen direction (1 = taken) |
| pr_glob | output | 1 | Global component direction |
| pr_local | output | 1 | Local component direction |
| up_valid | input | 1 | A branch resolved this cycle |
| up_pc | input | ADDR_W | Low address bits of the resolved branch |
| up_taken | input | 1 | Real outcome (1 = taken) |
| up_glob_pred | input | 1 | Global guess made for that branch |
| up_local_pred | input | 1 | Local guess made for that branch |

ADDR_W is the largest of HIST_W, LOC_W and SEL_W.

## Verification
A lookup and an update can land in the same cycle, often on the very same counters and chooser, and the update also shifts the history that forms the next global index. The bench drives each lookup and the update of the same branch in one cycle, samples the outputs before the edge against the pre-update model state and again after the edge against the trained state. Long address and outcome streams over a small configuration make this overlap happen on every step, across saturation limits and all chooser transitions.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_RESET = 2'b01;  // weakly not taken
  localparam ctr2_t SEL_RESET = 2'b10;  // weakly favour the global component

  // Saturating step toward the real outcome.
  function automatic ctr2_t ctr_train(input ctr2_t cur, input logic taken);
    ctr2_t nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  // Chooser step by the difference in correctness.
  function automatic ctr2_t sel_train(input ctr2_t cur, input logic first_ok,
                                      input logic second_ok);
    ctr2_t nxt;
    nxt = cur;
    if (first_ok && !second_ok && cur != 2'b11) nxt = cur + 2'd1;
    if (!first_ok && second_ok && cur != 2'b00) nxt = cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import tp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= CTR_RESET;
      else if (wr_en && wr_idx == IDX_W'(i))
        ent[i] <= ctr_train(ent[i], wr_taken);
    end
  end

  assign rd_taken = ent[rd_idx][1];

endmodule

// File: rtl/tp_sel_table.sv
module tp_sel_table #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_use_first,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             first_ok,
  input  logic             second_ok,
  output logic             inc_ev,
  output logic             dec_ev
);
  import tp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t ent [DEPTH];

  // Requests to move the addressed chooser (before saturation).
  assign inc_ev = wr_en &&  first_ok && !second_ok;
  assign dec_ev = wr_en && !first_ok &&  second_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= SEL_RESET;
      else if (wr_en && wr_idx == IDX_W'(i))
        ent[i] <= sel_train(ent[i], first_ok, second_ok);
    end
  end

  assign rd_use_first = ent[rd_idx][1];

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int HIST_W = 8,
  parameter int LOC_W  = 8,
  parameter int SEL_W  = 8,
  localparam int ADDR_W = (HIST_W > LOC_W) ? ((HIST_W > SEL_W) ? HIST_W : SEL_W)
                                           : ((LOC_W  > SEL_W) ? LOC_W  : SEL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pr_pc,
  output logic              pr_final,
  output logic              pr_glob,
  output logic              pr_local,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  input  logic              up_glob_pred,
  input  logic              up_local_pred
);

  logic [HIST_W-1:0] ghist_q;
  logic [HIST_W-1:0] g_rd_idx, g_wr_idx;
  logic              use_glob;
  logic              glob_ok, local_ok;
  logic              sel_inc_ev, sel_dec_ev;

  assign g_rd_idx = pr_pc[HIST_W-1:0] ^ ghist_q;
  assign g_wr_idx = up_pc[HIST_W-1:0] ^ ghist_q;
  assign glob_ok  = (up_glob_pred  == up_taken);
  assign local_ok = (up_local_pred == up_taken);

  tp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(up_valid), .shift_bit(up_taken),
    .hist(ghist_q)
  );

  tp_ctr_table #(.IDX_W(HIST_W)) u_glob (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(g_rd_idx), .rd_taken(pr_glob),
    .wr_en(up_valid), .wr_idx(g_wr_idx), .wr_taken(up_taken)
  );

  tp_ctr_table #(.IDX_W(LOC_W)) u_local (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pr_pc[LOC_W-1:0]), .rd_taken(pr_local),
    .wr_en(up_valid), .wr_idx(up_pc[LOC_W-1:0]), .wr_taken(up_taken)
  );

  tp_sel_table #(.IDX_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pr_pc[SEL_W-1:0]), .rd_use_first(use_glob),
    .wr_en(up_valid), .wr_idx(up_pc[SEL_W-1:0]),
    .first_ok(glob_ok), .second_ok(local_ok),
    .inc_ev(sel_inc_ev), .dec_ev(sel_dec_ev)
  );

  assign pr_final = use_glob ? pr_glob : pr_local;

endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_taken,
  input logic              up_glob_pred,
  input logic              up_local_pred,
  input logic              pr_final,
  input logic              pr_glob,
  input logic              pr_local,
  input logic [HIST_W-1:0] ghist,
  input logic              sel_inc,
  input logic              sel_dec
);

  // R9
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist == {$past(ghist[HIST_W-2:0]), $past(up_taken)});

  // R11
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && ((up_glob_pred == up_taken) == (up_local_pred == up_taken)))
      |-> !sel_inc && !sel_dec);

  // R7
  sel_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_glob_pred == up_taken && up_local_pred != up_taken)
      |-> sel_inc && !sel_dec);

  // R7
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_inc, sel_dec}));

  // R6
  final_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_glob == pr_local) |-> pr_final == pr_glob);

endmodule

bind tourney_predictor tp_chk #(.HIST_W(HIST_W)) u_tp_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken),
  .up_glob_pred(up_glob_pred), .up_local_pred(up_local_pred),
  .pr_final(pr_final), .pr_glob(pr_glob), .pr_local(pr_local),
  .ghist(ghist_q), .sel_inc(sel_inc_ev), .sel_dec(sel_dec_ev)
);

// File: tb/tourney_predictor_bench.sv
`timescale 1ns/1ps
module tourney_predictor_bench;
  localparam int HW = 4;
  localparam int LW = 3;
  localparam int SW = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] pr_pc = '0;
  logic pr_final, pr_glob, pr_local;
  logic up_valid = 1'b0;
  logic [AW-1:0] up_pc = '0;
  logic up_taken = 1'b0, up_glob_pred = 1'b0, up_local_pred = 1'b0;

  tourney_predictor #(.HIST_W(HW), .LOC_W(LW), .SEL_W(SW)) u_tourney_predictor (
    .clk(clk), .rst_n(rst_n), .pr_pc(pr_pc), .pr_final(pr_final),
    .pr_glob(pr_glob), .pr_local(pr_local), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_glob_pred(up_glob_pred), .up_local_pred(up_local_pred)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  int mg [16];
  int ml [8];
  int ms [4];
  int mh;
  int unsigned seed = 32'h1234_5678;

  function automatic int sat(int v);
    return (v < 0) ? 0 : ((v > 3) ? 3 : v);
  endfunction

  function automatic int nextrand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b (pc=%0d hist=%0h)", tag, act, exp, pr_pc, mh);
    end
  endtask

  task automatic check_lookup(input int pc, input string sfx);
    int gi, li, si;
    logic eg, el, ef;
    gi = (pc ^ mh) & 15; li = pc & 7; si = pc & 3;
    eg = mg[gi][1]; el = ml[li][1];
    ef = ms[si][1] ? eg : el;
    check(pr_glob,  eg, {"R2 R4 R5 R9 glob", sfx});
    check(pr_local, el, {"R3 R4 R5 local", sfx});
    check(pr_final, ef, {"R6 R7 R8 final", sfx});
  endtask

  // One lookup plus one update of the same branch in the same cycle.
  task automatic step(input int pc, input logic taken, input logic valid,
                      input logic gp_alt, input logic lp_alt);
    int gi, li, si;
    logic eg, el, gok, lok;
    @(negedge clk);
    pr_pc = AW'(pc);
    gi = (pc ^ mh) & 15; li = pc & 7; si = pc & 3;
    eg = mg[gi][1]; el = ml[li][1];
    up_valid = valid; up_pc = AW'(pc); up_taken = taken;
    up_glob_pred = valid ? eg : gp_alt;
    up_local_pred = valid ? el : lp_alt;
    #1;
    check_lookup(pc, " R10 pre-edge");
    @(posedge clk);
    if (valid) begin
      gok = (eg == taken); lok = (el == taken);
      mg[gi] = sat(mg[gi] + (taken ? 1 : -1));
      ml[li] = sat(ml[li] + (taken ? 1 : -1));
      if (gok && !lok) ms[si] = sat(ms[si] + 1);
      if (!gok && lok) ms[si] = sat(ms[si] - 1);
      mh = ((mh << 1) | int'(taken)) & 15;
    end
    #1;
    check_lookup(pc, valid ? " R10 post-edge" : " R11 no update");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 16; i++) mg[i] = 1;
    for (int i = 0; i < 8; i++)  ml[i] = 1;
    for (int i = 0; i < 4; i++)  ms[i] = 2;
    mh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state across every address
    for (int pc = 0; pc < 16; pc++) begin
      @(negedge clk); pr_pc = AW'(pc); #1;
      check(pr_glob,  1'b0, "R1 glob after reset");
      check(pr_local, 1'b0, "R1 local after reset");
      check(pr_final, 1'b0, "R1 final after reset");
    end

    // R4 R5: drive one address to saturation both ways (always-taken then never)
    for (int n = 0; n < 6; n++) step(5, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 6; n++) step(5, 1'b0, 1'b1, 1'b0, 1'b0);

    // Mixed streams: biased, alternating and history-correlated branches
    for (int n = 0; n < 3000; n++) begin
      int pc, r;
      logic t;
      r  = nextrand();
      pc = r & 15;
      case (pc & 3)
        0: t = 1'b1;
        1: t = 1'b0;
        2: t = logic'(mh & 1);
        default: t = logic'((r >> 5) & 1);
      endcase
      step(pc, t, 1'b1, 1'b0, 1'b0);
    end

    // R11: update inputs wiggle with up_valid low
    for (int n = 0; n < 64; n++) begin
      int r;
      r = nextrand();
      step(r & 15, logic'((r >> 4) & 1), 1'b0, logic'((r >> 6) & 1), logic'((r >> 7) & 1));
    end
    for (int pc = 0; pc < 16; pc++) begin
      @(negedge clk); pr_pc = AW'(pc); #1;
      check_lookup(pc, " R11 sweep");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule